// File: doc/BRIEF.md
# Oscillator Failover Monitor

This block watches a main oscillator against an always-running internal oscillator. It works entirely in the internal-oscillator domain. A free-running counter in the main-oscillator domain counts rising edges and is carried across as a Gray code. The internal side turns the count into edges per window, where a window is a fixed number of internal-oscillator cycles, and compares that figure against programmable inclusive low and high limits. The first window after the checker is enabled, and the first window after each recovery, only sets a baseline and is not judged.

When a judged window falls outside the limits, a recovery state machine steps through a fixed order, one step per cycle:
- set a sticky failure-cause flag;
- force the internal oscillator on;
- move the system clock select to the internal oscillator;
- hold a system reset for 32 internal-oscillator cycles;
- raise a one-cycle NMI request as the reset lets go.

The cause flag and the forcing outlive the generated reset. Software clears them with a one-cycle clear pulse. The power-on reset also clears them.

The state machine has six states:
- `ST_MON`: monitoring.
- `ST_FLAG`: setting the cause flag.
- `ST_IOSC_ON`: forcing the internal oscillator on.
- `ST_SWITCH`: moving the clock select.
- `ST_RESET`: holding the reset.
- `ST_NMI`: issuing the NMI request.

Its transitions are:
- `ST_MON` goes to `ST_FLAG` on a judged out-of-band window.
- `ST_FLAG` goes to `ST_IOSC_ON`, `ST_IOSC_ON` goes to `ST_SWITCH`, and `ST_SWITCH` goes to `ST_RESET`, each unconditionally.
- `ST_RESET` goes to `ST_NMI` after its 32nd cycle.
- `ST_NMI` goes back to `ST_MON` unconditionally.

Top module: `osc_fail_monitor`

## Requirements
- R1: While `chk_en` is 0, no window is judged and no recovery starts, whatever the main oscillator does.
- R2: A window lasts WIN_LEN (64) internal-oscillator cycles. A judged window whose count of main-oscillator rising edges lies below `band_lo` or above `band_hi` (both limits inclusive) starts recovery. A count inside the limits does not.
- R3: The first window after `chk_en` rises, and the first window after a recovery, is a baseline only. With a stopped main oscillator, `fail_flag` stays 0 until the second window has ended.
- R4: The first visible step of recovery is `fail_flag` going to 1.
- R5: One cycle after `fail_flag` rises, `iosc_en` is forced to 1.
- R6: One cycle after `iosc_en` is forced, `clk_sel` is forced to 1. The encoding is 0 for the main oscillator and 1 for the internal oscillator.
- R7: One cycle after `clk_sel` is forced, `sys_rst` goes high and stays high for exactly 32 internal-oscillator cycles.
- R8: `nmi_req` is high for exactly one cycle, in the first cycle in which `sys_rst` is low again.
- R9: `fail_flag` survives the generated reset. It is cleared by a one-cycle `fail_clr` pulse while monitoring, or by `por_n` low. After power-on reset every output is 0 when the software requests are 0.
- R10: Outside forcing, `iosc_en` follows `iosc_en_sw` and `clk_sel` follows `clk_sel_sw`. Clearing `fail_flag` releases the forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iosc_clk | input | 1 | Internal oscillator clock; all judging and control logic runs on it |
| mosc_clk | input | 1 | Main oscillator clock being monitored |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| chk_en | input | 1 | Enables the frequency check |
| band_lo | input | CNT_W | Lowest allowed edge count per window |
| band_hi | input | CNT_W | Highest allowed edge count per window |
| fail_clr | input | 1 | Software clear of the failure flag and forcing |
| iosc_en_sw | input | 1 | Software request to run the internal oscillator |
| clk_sel_sw | input | 1 | Software clock select (0 main, 1 internal) |
| iosc_en | output | 1 | Internal oscillator enable (software or forced) |
| clk_sel | output | 1 | System clock select (0 main, 1 internal) |
| fail_flag | output | 1 | Sticky main-oscillator failure cause |
| sys_rst | output | 1 | Generated system reset, active high |
| nmi_req | output | 1 | One-cycle NMI request after the reset |

## Verification
The bench drives the main clock at several rates and also stops it entirely. It places the measured count just inside and well outside a range of limits, so a comparator that used the wrong limit or excluded an endpoint would flag healthy clocks. It times every step of recovery cycle by cycle. A machine that merged two steps, or held the reset for 31 or 33 cycles, would miss the expected edge. An NMI raised while the reset was still high would do the same. It also checks that the first window is ignored, that a disabled checker ignores a dead clock, and that the flag survives the generated reset yet yields to both the software clear and power-on reset.

// File: rtl/osc_mon_pkg.sv
`timescale 1ns/1ps
package osc_mon_pkg;

    typedef enum logic [2:0] {
        ST_MON     = 3'd0,
        ST_FLAG    = 3'd1,
        ST_IOSC_ON = 3'd2,
        ST_SWITCH  = 3'd3,
        ST_RESET   = 3'd4,
        ST_NMI     = 3'd5
    } rec_state_e;

endpackage

// File: rtl/osc_mon_edge_gray.sv
`timescale 1ns/1ps
// Free-running rising-edge counter in the main-oscillator domain,
// published as a registered Gray code so only one bit changes per edge.
module osc_mon_edge_gray #(
    parameter int CNT_W = 12
) (
    input  logic             mosc_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_q
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    always_ff @(posedge mosc_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

endmodule

// File: rtl/osc_mon_gray_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded count, followed by conversion to binary.
module osc_mon_gray_sync #(
    parameter int CNT_W  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);

    logic [CNT_W-1:0] pipe [STAGES];
    logic [CNT_W-1:0] g_last;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= gray_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign g_last = pipe[STAGES-1];

    always_comb begin
        bin_out[CNT_W-1] = g_last[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ g_last[i];
        end
    end

endmodule

// File: rtl/osc_mon_window.sv
`timescale 1ns/1ps
// Window timer and band comparator in the internal-oscillator domain.
// The first window end after clr only captures a baseline.
module osc_mon_window #(
    parameter int CNT_W   = 12,
    parameter int WIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] count_in,
    input  logic [CNT_W-1:0] band_lo,
    input  logic [CNT_W-1:0] band_hi,
    output logic             err_o
);

    localparam int WW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

    logic [WW-1:0]    wcnt_q;
    logic [CNT_W-1:0] prev_q;
    logic             base_ok_q;
    logic [CNT_W-1:0] delta;
    logic             win_end;
    logic             out_of_band;

    assign delta       = count_in - prev_q;
    assign win_end     = (wcnt_q == LAST);
    assign out_of_band = (delta < band_lo) || (delta > band_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q    <= '0;
            prev_q    <= '0;
            base_ok_q <= 1'b0;
            err_o     <= 1'b0;
        end else if (clr) begin
            wcnt_q    <= '0;
            base_ok_q <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            err_o <= 1'b0;
            if (win_end) begin
                wcnt_q    <= '0;
                prev_q    <= count_in;
                base_ok_q <= 1'b1;
                if (base_ok_q && out_of_band) err_o <= 1'b1;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/osc_fail_monitor.sv
`timescale 1ns/1ps
module osc_fail_monitor
    import osc_mon_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int WIN_LEN     = 64,
    parameter int RST_CYC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             iosc_clk,
    input  logic             mosc_clk,
    input  logic             por_n,
    input  logic             chk_en,
    input  logic [CNT_W-1:0] band_lo,
    input  logic [CNT_W-1:0] band_hi,
    input  logic             fail_clr,
    input  logic             iosc_en_sw,
    input  logic             clk_sel_sw,
    output logic             iosc_en,
    output logic             clk_sel,
    output logic             fail_flag,
    output logic             sys_rst,
    output logic             nmi_req
);

    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [RW-1:0] RST_LAST = RW'(RST_CYC - 1);

    logic [CNT_W-1:0] mosc_gray;
    logic [CNT_W-1:0] mosc_count;
    logic             win_clr;
    logic             band_err;

    rec_state_e       state_q, state_d;
    logic [RW-1:0]    rcnt_q;
    logic             force_on_q;
    logic             force_sel_q;

    // Edge counting in the main-oscillator domain.
    osc_mon_edge_gray #(.CNT_W(CNT_W)) u_edge (
        .mosc_clk (mosc_clk),
        .rst_n    (por_n),
        .gray_q   (mosc_gray)
    );

    // Crossing into the internal-oscillator domain.
    osc_mon_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (iosc_clk),
        .rst_n   (por_n),
        .gray_in (mosc_gray),
        .bin_out (mosc_count)
    );

    // Windows restart whenever the check is off or recovery is running.
    assign win_clr = !chk_en || (state_q != ST_MON);

    osc_mon_window #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_win (
        .clk      (iosc_clk),
        .rst_n    (por_n),
        .clr      (win_clr),
        .count_in (mosc_count),
        .band_lo  (band_lo),
        .band_hi  (band_hi),
        .err_o    (band_err)
    );

    // State register and reset-length counter.
    always_ff @(posedge iosc_clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_MON;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RESET) rcnt_q <= rcnt_q + 1'b1;
            else                     rcnt_q <= '0;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MON:     if (band_err) state_d = ST_FLAG;
            ST_FLAG:    state_d = ST_IOSC_ON;
            ST_IOSC_ON: state_d = ST_SWITCH;
            ST_SWITCH:  state_d = ST_RESET;
            ST_RESET:   if (rcnt_q == RST_LAST) state_d = ST_NMI;
            ST_NMI:     state_d = ST_MON;
            default:    state_d = ST_MON;
        endcase
    end

    // Registered outputs, one step per state.
    always_ff @(posedge iosc_clk or negedge por_n) begin
        if (!por_n) begin
            fail_flag   <= 1'b0;
            force_on_q  <= 1'b0;
            force_sel_q <= 1'b0;
            sys_rst     <= 1'b0;
            nmi_req     <= 1'b0;
        end else begin
            sys_rst <= (state_q == ST_RESET);
            nmi_req <= (state_q == ST_NMI);
            if (state_q == ST_FLAG)
                fail_flag <= 1'b1;
            else if (fail_clr && state_q == ST_MON)
                fail_flag <= 1'b0;
            if (state_q == ST_IOSC_ON)
                force_on_q <= 1'b1;
            else if (fail_clr && state_q == ST_MON)
                force_on_q <= 1'b0;
            if (state_q == ST_SWITCH)
                force_sel_q <= 1'b1;
            else if (fail_clr && state_q == ST_MON)
                force_sel_q <= 1'b0;
        end
    end

    assign iosc_en = iosc_en_sw | force_on_q;
    assign clk_sel = clk_sel_sw | force_sel_q;

endmodule

// File: rtl/osc_mon_checker.sv
`timescale 1ns/1ps
module osc_mon_checker #(
    parameter int RST_CYC = 32
) (
    input logic clk,
    input logic por_n,
    input logic fail_clr,
    input logic iosc_en_sw,
    input logic clk_sel_sw,
    input logic iosc_en,
    input logic clk_sel,
    input logic fail_flag,
    input logic sys_rst,
    input logic nmi_req
);

    localparam int LW = $clog2(RST_CYC + 2) + 1;
    logic [LW-1:0] rst_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       rst_len <= '0;
        else if (sys_rst) rst_len <= rst_len + 1'b1;
        else              rst_len <= '0;
    end

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        fail_flag && !fail_clr |=> fail_flag);

    assert_flag_before_osc_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(iosc_en) && !iosc_en_sw |-> fail_flag);

    assert_osc_before_switch_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(clk_sel) && !clk_sel_sw |-> iosc_en);

    assert_switch_before_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> clk_sel && fail_flag);

    assert_reset_length_R7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> rst_len == LW'(RST_CYC));

    assert_nmi_after_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(nmi_req) |-> $fell(sys_rst));

    assert_nmi_single_R8: assert property (@(posedge clk) disable iff (!por_n)
        nmi_req |=> !nmi_req);

endmodule

bind osc_fail_monitor osc_mon_checker #(.RST_CYC(RST_CYC)) u_chk (
    .clk        (iosc_clk),
    .por_n      (por_n),
    .fail_clr   (fail_clr),
    .iosc_en_sw (iosc_en_sw),
    .clk_sel_sw (clk_sel_sw),
    .iosc_en    (iosc_en),
    .clk_sel    (clk_sel),
    .fail_flag  (fail_flag),
    .sys_rst    (sys_rst),
    .nmi_req    (nmi_req)
);

// File: tb/sim_osc_fail_monitor.sv
`timescale 1ns/1ps
module sim_osc_fail_monitor;

    localparam int CW    = 12;
    localparam int WIN   = 64;
    localparam int RSTC  = 32;
    localparam int VEC_N = 7;

    // main-clock half period in ns (0 = stopped), limits, expected failure
    localparam int V_HALF [VEC_N] = '{2,   1,   4,   4,  0,    0,  3};
    localparam int V_LO   [VEC_N] = '{120, 120, 120, 60, 1,    0,  80};
    localparam int V_HI   [VEC_N] = '{136, 136, 136, 70, 4000, 10, 90};
    localparam int V_EXP  [VEC_N] = '{0,   1,   1,   0,  1,    0,  0};

    logic iosc_clk = 1'b0;
    logic mosc_clk = 1'b0;
    logic por_n = 1'b0;
    logic chk_en = 1'b0;
    logic fail_clr = 1'b0;
    logic iosc_en_sw = 1'b0;
    logic clk_sel_sw = 1'b0;
    logic [CW-1:0] band_lo = '0;
    logic [CW-1:0] band_hi = '0;
    logic iosc_en, clk_sel, fail_flag, sys_rst, nmi_req;

    int mhalf = 2;
    int n_chk = 0;
    int n_bad = 0;

    osc_fail_monitor #(.CNT_W(CW), .WIN_LEN(WIN), .RST_CYC(RSTC)) u0 (
        .iosc_clk(iosc_clk), .mosc_clk(mosc_clk), .por_n(por_n), .chk_en(chk_en),
        .band_lo(band_lo), .band_hi(band_hi), .fail_clr(fail_clr),
        .iosc_en_sw(iosc_en_sw), .clk_sel_sw(clk_sel_sw), .iosc_en(iosc_en),
        .clk_sel(clk_sel), .fail_flag(fail_flag), .sys_rst(sys_rst), .nmi_req(nmi_req)
    );

    always #4 iosc_clk = ~iosc_clk;

    initial begin
        forever begin
            if (mhalf <= 0) begin
                mosc_clk = 1'b0;
                #1;
            end else begin
                #(mhalf) mosc_clk = ~mosc_clk;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge iosc_clk);
    endtask

    task automatic por();
        @(negedge iosc_clk);
        por_n = 1'b0;
        chk_en = 1'b0;
        fail_clr = 1'b0;
        cyc(3);
        por_n = 1'b1;
        cyc(2);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Walks recovery from the first visible flag to the end of the NMI pulse.
    task automatic check_sequence();
        int found = 0;
        int highs = 0;
        for (int k = 0; k < 400 && found == 0; k++) begin
            @(negedge iosc_clk);
            if (fail_flag) found = 1;
        end
        chk("R4 flag raised", found, 1);
        chk("R4 flag first, osc not yet forced", int'(iosc_en), 0);
        chk("R4 flag first, no reset yet", int'(sys_rst), 0);
        cyc(1);
        chk("R5 osc forced on", int'(iosc_en), 1);
        chk("R5 clock not yet switched", int'(clk_sel), 0);
        cyc(1);
        chk("R6 clock switched to internal", int'(clk_sel), 1);
        chk("R6 reset not yet asserted", int'(sys_rst), 0);
        cyc(1);
        for (int k = 0; k < 100 && sys_rst; k++) begin
            highs++;
            chk("R8 no nmi during reset", int'(nmi_req), 0);
            cyc(1);
        end
        chk("R7 reset length", highs, RSTC);
        chk("R8 nmi as reset releases", int'(nmi_req), 1);
        cyc(1);
        chk("R8 nmi single cycle", int'(nmi_req), 0);
        chk("R9 flag survives generated reset", int'(fail_flag), 1);
    endtask

    initial begin
        repeat (200000) @(posedge iosc_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // Reset state
        por();
        chk("R9 reset fail_flag", int'(fail_flag), 0);
        chk("R9 reset iosc_en", int'(iosc_en), 0);
        chk("R9 reset clk_sel", int'(clk_sel), 0);
        chk("R9 reset sys_rst", int'(sys_rst), 0);
        chk("R9 reset nmi_req", int'(nmi_req), 0);

        // Software requests pass through
        iosc_en_sw = 1'b1;
        clk_sel_sw = 1'b1;
        cyc(1);
        chk("R10 iosc_en follows request", int'(iosc_en), 1);
        chk("R10 clk_sel follows request", int'(clk_sel), 1);
        iosc_en_sw = 1'b0;
        clk_sel_sw = 1'b0;
        cyc(1);
        chk("R10 iosc_en released", int'(iosc_en), 0);
        chk("R10 clk_sel released", int'(clk_sel), 0);

        // Vector table
        for (int i = 0; i < VEC_N; i++) begin
            mhalf = V_HALF[i];
            band_lo = CW'(V_LO[i]);
            band_hi = CW'(V_HI[i]);
            por();
            chk_en = 1'b1;
            cyc(5 * WIN + 50);
            chk($sformatf("R2 vector %0d fail_flag", i), int'(fail_flag), V_EXP[i]);
        end

        // Checker disabled ignores a dead clock
        mhalf = 0;
        band_lo = CW'(100);
        band_hi = CW'(200);
        por();
        cyc(6 * WIN);
        chk("R1 disabled no flag", int'(fail_flag), 0);
        chk("R1 disabled no reset", int'(sys_rst), 0);
        chk("R1 disabled no forcing", int'(iosc_en), 0);

        // Baseline window, then full ordered sequence
        chk_en = 1'b1;
        cyc(WIN + WIN / 2);
        chk("R3 baseline window not judged", int'(fail_flag), 0);
        check_sequence();

        // Restore a good clock; flag and forcing persist until cleared
        mhalf = 2;
        band_lo = CW'(120);
        band_hi = CW'(136);
        cyc(4 * WIN);
        chk("R9 flag sticky with good clock", int'(fail_flag), 1);
        chk("R10 osc still forced", int'(iosc_en), 1);
        chk("R10 clock still forced", int'(clk_sel), 1);
        chk("R3 no refire after recovery with good clock", int'(sys_rst), 0);
        fail_clr = 1'b1;
        cyc(1);
        fail_clr = 1'b0;
        chk("R9 software clear", int'(fail_flag), 0);
        chk("R10 forcing released iosc_en", int'(iosc_en), 0);
        chk("R10 forcing released clk_sel", int'(clk_sel), 0);

        // Fail again, then power-on reset clears the flag
        mhalf = 0;
        cyc(4 * WIN);
        chk("R2 stopped clock flagged", int'(fail_flag), 1);
        por();
        chk("R9 power-on clears flag", int'(fail_flag), 0);
        chk("R9 power-on clears forcing", int'(clk_sel), 0);

        summary();
    end

endmodule